// File: doc/BRIEF.md
# Modem Control Output Selector

This block is the modem-control register slice of a 16550-style serial port. The host writes a small control word that drives the two active-low handshake outputs, data-terminal-ready (`dtr_n_o`) and request-to-send (`rts_n_o`). When automatic hardware flow control is enabled, one control bit picks which output/input pair does the handshaking. With that bit clear, the request-to-send output is paired with the clear-to-send input. With that bit set, the data-terminal-ready output is paired with the data-set-ready input. The selected output is pulled inactive while the receive FIFO is at or above its threshold. The other output stays a general-purpose output.

In local loopback the external handshake pins are parked high. The internal output levels and the two user output bits are routed into the modem-status bits, and the selection bit serves as user output 1, which feeds the ring-indicator status. A transmit permission signal tells the shifter whether it may send under automatic flow control.

Control word layout, as read back in bits 4:0 of `rd_data`:

- bit 0: DTR drive
- bit 1: RTS drive
- bit 2: pair select / user output 1
- bit 3: user output 2
- bit 4: loopback

Top module: `mdm_ctl_sel`

## Requirements
- R1: A cycle with `wr_en`=1 stores `wr_data[4:0]` as the control word on that clock edge, and `rd_data` returns it in bits 4:0 with bits 7:5 reading 0 regardless of what was written there.
- R2: After reset the control word is 0 and both `dtr_n_o` and `rts_n_o` are 1. The pins are registered, so they change on the clock edge after the control word changes.
- R3: With automatic flow control off and loopback off, control bit 1 = 1 drives `rts_n_o` low and bit 1 = 0 drives it high.
- R4: With automatic flow control off and loopback off, control bit 0 = 1 drives `dtr_n_o` low and bit 0 = 0 drives it high.
- R5: With `auto_fc_en`=1, loopback off and bit 2 = 0, `rts_n_o` is low only when bit 1 = 1 and `rx_above_thr`=0. `dtr_n_o` follows bit 0 as in R4.
- R6: With `auto_fc_en`=1, loopback off and bit 2 = 1, `dtr_n_o` is low only when bit 0 = 1 and `rx_above_thr`=0. `rts_n_o` follows bit 1 as in R3.
- R7: With `auto_fc_en`=0, neither bit 2 nor `rx_above_thr` has any effect on the pins.
- R8: With bit 4 = 1 (loopback), both pins are 1 and the external modem inputs are ignored. The status bits are: `st_cts` = bit 1, `st_dsr` = bit 0, `st_ri` = bit 2, `st_dcd` = bit 3. The threshold input does not act on these levels.
- R9: With loopback off, each status bit is the inverse of its active-low input pin (`cts_n_i`, `dsr_n_i`, `ri_n_i`, `dcd_n_i`).
- R10: `tx_allow` is 1 when `auto_fc_en`=0. Otherwise it equals `st_cts` when bit 2 = 0 and `st_dsr` when bit 2 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write data |
| rd_data | output | 8 | Control word read-back |
| auto_fc_en | input | 1 | Automatic flow control enable |
| rx_above_thr | input | 1 | Receive FIFO at or above threshold |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| ri_n_i | input | 1 | Ring indicator pin, active low |
| dcd_n_i | input | 1 | Carrier detect pin, active low |
| dtr_n_o | output | 1 | Data-terminal-ready pin, active low |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| st_cts | output | 1 | Clear-to-send status, active high |
| st_dsr | output | 1 | Data-set-ready status, active high |
| st_ri | output | 1 | Ring indicator status, active high |
| st_dcd | output | 1 | Carrier detect status, active high |
| tx_allow | output | 1 | Transmitter may send |

## Verification
A corrupted control word shows at once on `rd_data` and on the loopback status bits. It shows on the pins one edge later.

A wrong choice of pair shows only while automatic flow control is on and the threshold input is high. The wrong pin goes high, or the wrong one stays low. So each pair is driven with the threshold both high and low, and the pins are sampled two edges after each write.

A mix-up between loopback and normal status routing shows in the same cycle as the write. It is exposed by driving external inputs that disagree with the internal levels.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int CTL_W = 5;

  typedef struct packed {
    logic loop;  // bit 4
    logic op2;   // bit 3
    logic sel;   // bit 2: pair select / user output 1
    logic rts;   // bit 1
    logic dtr;   // bit 0
  } ctl_t;
endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
  import mdm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_t              ctl,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - CTL_W;

  ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = ctl_t'(wr_data[CTL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl     = ctl_q;
  assign rd_data = {{PAD_W{1'b0}}, ctl_q};

  // R1: a write lands in the control word on the next edge
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[CTL_W-1:0] == $past(wr_data[CTL_W-1:0])));
endmodule

// File: rtl/mdm_pin_drv.sv
module mdm_pin_drv
  import mdm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t ctl,
  input  logic auto_fc_en,
  input  logic rx_above_thr,
  output logic dtr_int,
  output logic rts_int,
  output logic dtr_n_o,
  output logic rts_n_o
);
  logic auto_act, dtr_hold, rts_hold;
  logic dtr_n_d, rts_n_d, dtr_n_q, rts_n_q;

  always_comb begin
    auto_act = auto_fc_en & ~ctl.loop;
    dtr_hold = auto_act &  ctl.sel & rx_above_thr;
    rts_hold = auto_act & ~ctl.sel & rx_above_thr;
    dtr_int  = ctl.dtr & ~dtr_hold;
    rts_int  = ctl.rts & ~rts_hold;
    dtr_n_d  = ctl.loop | ~dtr_int;
    rts_n_d  = ctl.loop | ~rts_int;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dtr_n_q <= 1'b1;
      rts_n_q <= 1'b1;
    end else begin
      dtr_n_q <= dtr_n_d;
      rts_n_q <= rts_n_d;
    end
  end

  assign dtr_n_o = dtr_n_q;
  assign rts_n_o = rts_n_q;

  // R8: pins parked high one edge after loopback is seen
  p_loop_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl.loop) |-> (dtr_n_o && rts_n_o));
  // R6: selected DTR released while the FIFO is over threshold
  p_dtr_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(auto_fc_en && !ctl.loop && ctl.sel && rx_above_thr) |-> dtr_n_o);
  // R5: selected RTS released while the FIFO is over threshold
  p_rts_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(auto_fc_en && !ctl.loop && !ctl.sel && rx_above_thr) |-> rts_n_o);
endmodule

// File: rtl/mdm_loop_mux.sv
module mdm_loop_mux
  import mdm_pkg::*;
(
  input  ctl_t ctl,
  input  logic dtr_int,
  input  logic rts_int,
  input  logic auto_fc_en,
  input  logic cts_n_i,
  input  logic dsr_n_i,
  input  logic ri_n_i,
  input  logic dcd_n_i,
  output logic st_cts,
  output logic st_dsr,
  output logic st_ri,
  output logic st_dcd,
  output logic tx_allow
);
  always_comb begin
    if (ctl.loop) begin
      st_cts = rts_int;
      st_dsr = dtr_int;
      st_ri  = ctl.sel;
      st_dcd = ctl.op2;
    end else begin
      st_cts = ~cts_n_i;
      st_dsr = ~dsr_n_i;
      st_ri  = ~ri_n_i;
      st_dcd = ~dcd_n_i;
    end
    tx_allow = ~auto_fc_en | (ctl.sel ? st_dsr : st_cts);
  end
endmodule

// File: rtl/mdm_ctl_sel.sv
module mdm_ctl_sel
  import mdm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              auto_fc_en,
  input  logic              rx_above_thr,
  input  logic              cts_n_i,
  input  logic              dsr_n_i,
  input  logic              ri_n_i,
  input  logic              dcd_n_i,
  output logic              dtr_n_o,
  output logic              rts_n_o,
  output logic              st_cts,
  output logic              st_dsr,
  output logic              st_ri,
  output logic              st_dcd,
  output logic              tx_allow
);
  ctl_t ctl;
  logic dtr_int, rts_int;

  mdm_ctl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctl(ctl), .rd_data(rd_data)
  );

  mdm_pin_drv u_pins (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .auto_fc_en(auto_fc_en),
    .rx_above_thr(rx_above_thr), .dtr_int(dtr_int), .rts_int(rts_int),
    .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o)
  );

  mdm_loop_mux u_mux (
    .ctl(ctl), .dtr_int(dtr_int), .rts_int(rts_int), .auto_fc_en(auto_fc_en),
    .cts_n_i(cts_n_i), .dsr_n_i(dsr_n_i), .ri_n_i(ri_n_i), .dcd_n_i(dcd_n_i),
    .st_cts(st_cts), .st_dsr(st_dsr), .st_ri(st_ri), .st_dcd(st_dcd),
    .tx_allow(tx_allow)
  );

  // R10: transmitter held when the selected handshake input is inactive
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_fc_en && ((rd_data[2] && !st_dsr) || (!rd_data[2] && !st_cts))) |-> !tx_allow);
  // R7: without automatic flow control the pins mirror the stored bits
  p_gp_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!auto_fc_en && !rd_data[4]) |->
      (dtr_n_o == !$past(rd_data[0]) && rts_n_o == !$past(rd_data[1])));
  // R1: upper read-back bits stay zero
  p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:CTL_W] == '0);
endmodule

// File: tb/tb_mdm_ctl_sel.sv
module tb_mdm_ctl_sel;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [7:0] wr_data, rd_data;
  logic auto_fc_en, rx_above_thr, cts_n_i, dsr_n_i, ri_n_i, dcd_n_i;
  logic dtr_n_o, rts_n_o, st_cts, st_dsr, st_ri, st_dcd, tx_allow;

  always #2 clk = ~clk;

  mdm_ctl_sel dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .auto_fc_en(auto_fc_en), .rx_above_thr(rx_above_thr),
    .cts_n_i(cts_n_i), .dsr_n_i(dsr_n_i), .ri_n_i(ri_n_i), .dcd_n_i(dcd_n_i),
    .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o), .st_cts(st_cts), .st_dsr(st_dsr),
    .st_ri(st_ri), .st_dcd(st_dcd), .tx_allow(tx_allow)
  );

  typedef struct {
    logic [7:0] rd;
    logic dtr_n, rts_n, cts, dsr, ri, dcd, txa;
    string tag;
  } exp_t;

  exp_t sb[$];
  event chk_ev;
  int total = 0, bad = 0;
  bit done = 0;

  function automatic exp_t model(logic [4:0] c, logic au, logic thr,
                                 logic [3:0] pins_n, string tag);
    exp_t e;
    logic loop, sel, dtr_i, rts_i;
    loop = c[4]; sel = c[2];
    dtr_i = c[0]; rts_i = c[1];
    if (au && !loop && thr) begin
      if (sel) dtr_i = 1'b0; else rts_i = 1'b0;
    end
    e.rd = {3'b000, c};
    e.dtr_n = loop ? 1'b1 : !dtr_i;
    e.rts_n = loop ? 1'b1 : !rts_i;
    if (loop) begin
      e.cts = rts_i; e.dsr = dtr_i; e.ri = c[2]; e.dcd = c[3];
    end else begin
      e.cts = !pins_n[3]; e.dsr = !pins_n[2]; e.ri = !pins_n[1]; e.dcd = !pins_n[0];
    end
    e.txa = !au ? 1'b1 : (sel ? e.dsr : e.cts);
    e.tag = tag;
    return e;
  endfunction

  // pins_n = {cts_n, dsr_n, ri_n, dcd_n}
  task automatic drive(logic [7:0] w, logic au, logic thr, logic [3:0] pins_n, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w; auto_fc_en = au; rx_above_thr = thr;
    {cts_n_i, dsr_n_i, ri_n_i, dcd_n_i} = pins_n;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    sb.push_back(model(w[4:0], au, thr, pins_n, tag));
    -> chk_ev;
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (rd_data !== e.rd || dtr_n_o !== e.dtr_n || rts_n_o !== e.rts_n ||
            st_cts !== e.cts || st_dsr !== e.dsr || st_ri !== e.ri ||
            st_dcd !== e.dcd || tx_allow !== e.txa) begin
          bad++;
          $display("FAIL %s: got rd=%h dtr_n=%b rts_n=%b st=%b%b%b%b tx=%b exp rd=%h dtr_n=%b rts_n=%b st=%b%b%b%b tx=%b",
                   e.tag, rd_data, dtr_n_o, rts_n_o, st_cts, st_dsr, st_ri, st_dcd, tx_allow,
                   e.rd, e.dtr_n, e.rts_n, e.cts, e.dsr, e.ri, e.dcd, e.txa);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; auto_fc_en = 1'b0; rx_above_thr = 1'b0;
    {cts_n_i, dsr_n_i, ri_n_i, dcd_n_i} = 4'b1010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    sb.push_back(model(5'b0, 1'b0, 1'b0, 4'b1010, "R2 reset"));
    -> chk_ev;
    // R1 upper bits dropped
    drive(8'hE3, 1'b0, 1'b0, 4'b0101, "R1 readback pad");
    // R3 / R4 general purpose drive
    drive(8'h02, 1'b0, 1'b0, 4'b1111, "R3 rts low");
    drive(8'h01, 1'b0, 1'b0, 4'b0000, "R4 dtr low");
    drive(8'h00, 1'b0, 1'b0, 4'b1100, "R3 R4 both high");
    // R7 select and threshold ignored without auto
    drive(8'h07, 1'b0, 1'b1, 4'b1111, "R7 sel+thr ignored");
    drive(8'h03, 1'b0, 1'b1, 4'b0011, "R7 thr ignored sel0");
    // R5 RTS pair
    drive(8'h03, 1'b1, 1'b0, 4'b0111, "R5 below thr, cts low");
    drive(8'h03, 1'b1, 1'b1, 4'b1011, "R5 above thr, cts high");
    drive(8'h01, 1'b1, 1'b0, 4'b1111, "R5 rts bit off");
    // R6 DTR pair
    drive(8'h07, 1'b1, 1'b0, 4'b1011, "R6 below thr, dsr low");
    drive(8'h07, 1'b1, 1'b1, 4'b0111, "R6 above thr, dsr high");
    drive(8'h06, 1'b1, 1'b0, 4'b0000, "R6 dtr bit off");
    // R8 loopback
    drive(8'h1B, 1'b0, 1'b0, 4'b0000, "R8 loop op2 dtr rts");
    drive(8'h14, 1'b0, 1'b0, 4'b1111, "R8 loop op1 only");
    drive(8'h17, 1'b1, 1'b1, 4'b0000, "R8 loop auto thr ignored");
    // R9 normal status
    drive(8'h00, 1'b0, 1'b0, 4'b0110, "R9 status invert");
    // R10 tx gating
    drive(8'h00, 1'b1, 1'b0, 4'b1000, "R10 cts high blocks");
    drive(8'h04, 1'b1, 1'b0, 4'b1000, "R10 dsr low allows");
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule